// File: doc/BRIEF.md
# High Address Byte Generator

This block forms the upper byte of the 16-bit address of an 8-bit processor core. It works in two stages. A source stage picks a base value, which is zero, the high byte used in the previous cycle, the high byte of the program counter, or a byte from the data bus. An adjust stage then adds 0, adds 1, subtracts 1, or adds the carry that the low-byte address adder produced.

The three fixed pages need no constant inputs of their own. The zero page, the stack page and the vector page all come from the zero source with an adjust of +0, +1 or −1. Zero-page and stack accesses must not cross into the next page. The sequencer gets this by choosing a fixed adjust rather than the carry adjust, so a carry out of the low byte never reaches the high byte.

The new byte is given in two forms. A combinational form can drive a synchronous memory in the same cycle. A registered form is fed back and acts as the "previous" source in the next cycle.

Top module: `addr_hi_gen`

## Requirements
- R1: A synchronous reset sets the registered output to all ones (FF for W=8), and reset takes priority over the clock enable.
- R2: With source code 0 (zero), adjust code 0 (+0) gives 00, adjust code 1 (+1) gives 01, and adjust code 2 (−1) gives FF, on the combinational output.
- R3: With source code 1 (previous registered byte), adjust codes 2, 0 and 1 give previous−1, previous and previous+1.
- R4: Adjust code 3 adds carry_in to the selected byte: the result is the byte itself when carry_in is 0 and the byte plus 1 when carry_in is 1.
- R5: With adjust codes 0, 1 or 2, carry_in has no effect on the output, so accesses stay within their page.
- R6: Source code 2 selects pc_hi and source code 3 selects data_in.
- R7: All arithmetic is modulo 2^W. FF+1 gives 00 and 00−1 gives FF, and no carry leaves the block.
- R8: The combinational output reflects its inputs in the same cycle. On a clock edge with ce high and rst low, the registered output takes the combinational value. With ce low, the registered output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for the address register |
| src_sel | input | 2 | Source: 0 zero, 1 previous, 2 pc_hi, 3 data_in |
| adj_op | input | 2 | Adjust: 0 +0, 1 +1, 2 −1, 3 +carry_in |
| carry_in | input | 1 | Carry out of the low-byte address adder |
| pc_hi | input | W | Program counter high byte |
| data_in | input | W | Data bus byte |
| addr_comb | output | W | New high address byte, combinational |
| addr_q | output | W | Registered high address byte |

## Verification
The bench builds the block at the default W=8, so every possible base value can be tried. It loads each of the 256 values as the previous byte and checks −1, +0 and +1 on each one. This covers both wrap corners (00−1 and FF+1) and every internal borrow and carry chain of the adjust stage. At this width, the data path also reaches all ones, so the check that carry_in has no effect while the carry is gated is made at the byte where a leak would change the page.

// File: rtl/addr_hi_gen.sv
module addr_hi_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [1:0]   src_sel,
  input  logic [1:0]   adj_op,
  input  logic         carry_in,
  input  logic [W-1:0] pc_hi,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] addr_comb,
  output logic [W-1:0] addr_q
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] base;
  logic [W-1:0] addend;

  always_comb begin
    case (src_sel)
      2'd0:    base = '0;
      2'd1:    base = addr_q;
      2'd2:    base = pc_hi;
      default: base = data_in;
    endcase
  end

  always_comb begin
    case (adj_op)
      2'd0:    addend = '0;
      2'd1:    addend = ONE;
      2'd2:    addend = ALL_ONES;
      default: addend = {{(W-1){1'b0}}, carry_in};
    endcase
  end

  assign addr_comb = base + addend;

  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= ALL_ONES;
    else if (ce)
      addr_q <= addr_comb;
  end

endmodule

// File: rtl/addr_hi_gen_chk.sv
module addr_hi_gen_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ce,
  input logic [1:0]   src_sel,
  input logic [1:0]   adj_op,
  input logic         carry_in,
  input logic [W-1:0] pc_hi,
  input logic [W-1:0] data_in,
  input logic [W-1:0] addr_comb,
  input logic [W-1:0] addr_q
);

  a_r1_reset_ones: assert property (@(posedge clk)
    rst |=> addr_q == {W{1'b1}});

  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    ce |=> addr_q == $past(addr_comb));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(addr_q));

  a_r2_zero_page: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'd0 && adj_op == 2'd0) |-> addr_comb == '0);

  a_r2_vector_page: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'd0 && adj_op == 2'd2) |-> addr_comb == {W{1'b1}});

  a_r4_carry_only: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'd0 && adj_op == 2'd3) |-> addr_comb == {{(W-1){1'b0}}, carry_in});

  a_r6_pc_source: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'd2 && adj_op == 2'd0) |-> addr_comb == pc_hi);

  a_r6_data_source: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'd3 && adj_op == 2'd0) |-> addr_comb == data_in);

  a_r3_same_page: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'd1 && adj_op == 2'd0) |-> addr_comb == addr_q);

endmodule

bind addr_hi_gen addr_hi_gen_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .ce(ce), .src_sel(src_sel), .adj_op(adj_op),
  .carry_in(carry_in), .pc_hi(pc_hi), .data_in(data_in),
  .addr_comb(addr_comb), .addr_q(addr_q)
);

// File: tb/test_addr_hi_gen.sv
module test_addr_hi_gen;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ce = 1'b0;
  logic [1:0]   src_sel = '0;
  logic [1:0]   adj_op = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] pc_hi = '0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] addr_comb;
  logic [W-1:0] addr_q;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  addr_hi_gen #(.W(W)) i_addr_hi_gen (
    .clk(clk), .rst(rst), .ce(ce), .src_sel(src_sel), .adj_op(adj_op),
    .carry_in(carry_in), .pc_hi(pc_hi), .data_in(data_in),
    .addr_comb(addr_comb), .addr_q(addr_q)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [1:0] s, input logic [1:0] o, input logic c);
    @(negedge clk);
    src_sel = s; adj_op = o; carry_in = c;
    #1;
  endtask

  task automatic load_prev(input logic [W-1:0] v);
    @(negedge clk);
    src_sel = 2'd3; adj_op = 2'd0; data_in = v; ce = 1'b1;
    @(posedge clk); #1;
    ce = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; ce = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset value", addr_q, 8'hFF);
    @(negedge clk); rst = 1'b0; ce = 1'b0;
  endtask

  task automatic t_fixed_pages();
    set_in(2'd0, 2'd0, 1'b1); chk("R2 zero page", addr_comb, 8'h00);
    set_in(2'd0, 2'd1, 1'b1); chk("R2 stack page", addr_comb, 8'h01);
    set_in(2'd0, 2'd2, 1'b1); chk("R2 vector page", addr_comb, 8'hFF);
  endtask

  task automatic t_prev_sweep();
    for (int v = 0; v < 256; v++) begin
      load_prev(v[W-1:0]);
      chk("R8 load", addr_q, v[W-1:0]);
      set_in(2'd1, 2'd2, 1'b0); chk("R3 prev-1 R7", addr_comb, W'(v - 1));
      set_in(2'd1, 2'd0, 1'b0); chk("R3 prev+0", addr_comb, v[W-1:0]);
      set_in(2'd1, 2'd1, 1'b0); chk("R3 prev+1 R7", addr_comb, W'(v + 1));
    end
  endtask

  task automatic t_carry();
    load_prev(8'h3C);
    set_in(2'd1, 2'd3, 1'b0); chk("R4 carry 0", addr_comb, 8'h3C);
    set_in(2'd1, 2'd3, 1'b1); chk("R4 carry 1", addr_comb, 8'h3D);
    load_prev(8'hFF);
    set_in(2'd1, 2'd3, 1'b1); chk("R4 R7 carry wrap", addr_comb, 8'h00);
  endtask

  task automatic t_carry_gated();
    set_in(2'd0, 2'd0, 1'b1); chk("R5 zero page wrap", addr_comb, 8'h00);
    set_in(2'd0, 2'd1, 1'b1); chk("R5 stack wrap", addr_comb, 8'h01);
    load_prev(8'h80);
    set_in(2'd1, 2'd0, 1'b1); chk("R5 prev gated", addr_comb, 8'h80);
    set_in(2'd1, 2'd2, 1'b1); chk("R5 prev-1 gated", addr_comb, 8'h7F);
  endtask

  task automatic t_sources();
    @(negedge clk); pc_hi = 8'hA5; data_in = 8'h5A;
    set_in(2'd2, 2'd0, 1'b0); chk("R6 pc_hi", addr_comb, 8'hA5);
    set_in(2'd2, 2'd1, 1'b0); chk("R6 pc_hi+1", addr_comb, 8'hA6);
    set_in(2'd3, 2'd0, 1'b0); chk("R6 data_in", addr_comb, 8'h5A);
    set_in(2'd3, 2'd2, 1'b0); chk("R6 data_in-1", addr_comb, 8'h59);
  endtask

  task automatic t_hold_and_reset();
    load_prev(8'h42);
    @(negedge clk); src_sel = 2'd3; data_in = 8'h99; ce = 1'b0;
    repeat (3) @(posedge clk);
    #1; chk("R8 hold", addr_q, 8'h42);
    @(negedge clk); ce = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset over ce", addr_q, 8'hFF);
    @(negedge clk); rst = 1'b0; ce = 1'b0;
  endtask

  initial begin
    t_reset();
    t_fixed_pages();
    t_prev_sweep();
    t_carry();
    t_carry_gated();
    t_sources();
    t_hold_and_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule